// File: doc/BRIEF.md
# Receive-Only SPI Request Counter and Word Packer

This block drives receive-only SPI transfers. Software writes a byte count through a request port. From then on the block asks the shift engine to run its clock until that many bytes have come in, and no transmit data is needed. The shift engine returns one sample strobe per received bit. The block collects the bits most significant first into bytes, and the bytes into 32-bit words, then hands each word to the receive storage with a valid-byte count.

In receive-only operation every word is four bytes wide, whatever word length is configured elsewhere. When the request runs out before a word is full, the block emits the shorter word with a valid-byte count from 1 to 3. Its bytes are right-aligned, with the earliest byte in the most significant valid position. A readable counter shows how many bytes are still outstanding. Software normally requests no more than the storage can hold and issues the next request once it has drained the storage.

If a word is completed while the downstream side cannot accept it, the word is dropped and a sticky overflow flag is raised. A request written during an active request replaces the remaining count and discards any partly assembled word.

Top module: `rxo_spi_rx_packer`

## Requirements
- R1: After reset the remaining count is 0, the clock-run output is low, and no word, completion pulse or overflow is signalled.
- R2: A request write loads the remaining count from the 16-bit count input. The clock-run output is high exactly while the remaining count is non-zero, so writing 0 leaves the clock stopped.
- R3: Each completed group of 8 accepted bit strobes decrements the remaining count by one. Strobes that arrive while the remaining count is 0 change nothing.
- R4: Bits are shifted in most significant first. A full word carries four bytes, with the first received byte in bits 31:24 and a valid-byte field of 4 (3'b100). It is presented as a one-cycle valid pulse in the cycle after its last bit strobe.
- R5: When the count runs out with 1 to 3 bytes collected, a word is emitted whose valid-byte field equals that number. The bytes are right-aligned, the earliest byte is the most significant valid byte, and all bits above the valid bytes are zero.
- R6: When the remaining count reaches zero, the clock-run output drops and a one-cycle completion pulse is raised in the same cycle as the final word.
- R7: A word that completes while the downstream ready input is low is not presented. Instead the overflow flag is set, and it stays set until the next request write. Counting continues regardless.
- R8: A request write while a request is active replaces the remaining count and discards the partly assembled bits. A bit strobe in the same cycle as a request write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_we_i | input | 1 | Request write strobe |
| req_count_i | input | 16 | Number of bytes to receive |
| remaining_o | output | 16 | Bytes still outstanding |
| sclk_run_o | output | 1 | Asks the shift engine to generate clocks |
| bit_strobe_i | input | 1 | One received bit is valid on bit_i |
| bit_i | input | 1 | Received serial bit |
| word_ready_i | input | 1 | Downstream can accept a word this cycle |
| word_valid_o | output | 1 | One-cycle pulse: word outputs are valid |
| word_data_o | output | 32 | Packed receive word |
| word_nbytes_o | output | 3 | Valid bytes in the word (1 to 4) |
| rx_done_o | output | 1 | One-cycle pulse when the count reaches zero |
| overflow_o | output | 1 | Sticky: a completed word was dropped |

## Verification
The hardest situations to reach from the ports are a request write that lands while a byte is half assembled, and a write that lands in the very cycle a bit strobe arrives. A write that lands there must discard the partial bits and not count the strobe. The stimulus reaches both by cutting a byte off after a few bits and by driving the write and a strobe together. Both cases are followed by a full short transfer, so any leftover bits would show up in the next word. Partial-word lengths of 1, 2 and 3 bytes are each reached by request counts of 5, 6 and 7. Overflow is reached by holding ready low across the completing strobe. A behavioural reference model is compared with the design on every cycle.

// File: rtl/rxo_pkg.sv
package rxo_pkg;
    localparam int unsigned RXO_CNT_W      = 16;
    localparam int unsigned RXO_WORD_BYTES = 4;
    localparam int unsigned RXO_BYTE_W     = 8;

    function automatic int unsigned rxo_field_w(input int unsigned n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/rxo_req_counter.sv
module rxo_req_counter #(
    parameter int unsigned CNT_W = rxo_pkg::RXO_CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             byte_end_i,
    output logic [CNT_W-1:0] remaining_o,
    output logic             run_o,
    output logic             last_byte_o,
    output logic             done_o
);
    typedef struct packed {
        logic [CNT_W-1:0] rem;
        logic             done;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (load_i) begin
            s_d.rem = load_val_i;
        end else if (byte_end_i && (s_q.rem != '0)) begin
            s_d.rem = s_q.rem - CNT_W'(1);
            if (s_q.rem == CNT_W'(1)) begin
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign remaining_o = s_q.rem;
    assign run_o       = (s_q.rem != '0);
    assign last_byte_o = (s_q.rem == CNT_W'(1));
    assign done_o      = s_q.done;
endmodule

// File: rtl/rxo_assembler.sv
module rxo_assembler #(
    parameter int unsigned WORD_BYTES = rxo_pkg::RXO_WORD_BYTES,
    parameter int unsigned BYTE_W     = rxo_pkg::RXO_BYTE_W,
    localparam int unsigned WORD_W    = WORD_BYTES * BYTE_W,
    localparam int unsigned NB_W      = rxo_pkg::rxo_field_w(WORD_BYTES)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic              take_i,
    input  logic              bit_i,
    input  logic              last_byte_i,
    output logic              byte_end_o,
    output logic              word_end_o,
    output logic [WORD_W-1:0] word_o,
    output logic [NB_W-1:0]   nbytes_o
);
    localparam int unsigned IDX_W = $clog2(WORD_W);
    localparam int unsigned SUB_W = $clog2(BYTE_W);

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [IDX_W-1:0]  idx;
    } asm_state_t;

    asm_state_t s_d, s_q;
    logic [WORD_W-1:0] shifted;
    logic              at_byte_edge;
    logic              at_word_edge;

    always_comb begin
        shifted      = {s_q.acc[WORD_W-2:0], bit_i};
        at_byte_edge = (s_q.idx[SUB_W-1:0] == SUB_W'(BYTE_W - 1));
        at_word_edge = (s_q.idx == IDX_W'(WORD_W - 1));
        byte_end_o   = take_i && at_byte_edge;
        word_end_o   = byte_end_o && (at_word_edge || last_byte_i);
        nbytes_o     = NB_W'(s_q.idx >> SUB_W) + NB_W'(1);

        s_d = s_q;
        if (clear_i) begin
            s_d.acc = '0;
            s_d.idx = '0;
        end else if (take_i) begin
            if (word_end_o) begin
                s_d.acc = '0;
                s_d.idx = '0;
            end else begin
                s_d.acc = shifted;
                s_d.idx = s_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_o = shifted;
endmodule

// File: rtl/rxo_spi_rx_packer.sv
module rxo_spi_rx_packer #(
    parameter int unsigned CNT_W      = rxo_pkg::RXO_CNT_W,
    parameter int unsigned WORD_BYTES = rxo_pkg::RXO_WORD_BYTES,
    parameter int unsigned BYTE_W     = rxo_pkg::RXO_BYTE_W,
    localparam int unsigned WORD_W    = WORD_BYTES * BYTE_W,
    localparam int unsigned NB_W      = rxo_pkg::rxo_field_w(WORD_BYTES)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_we_i,
    input  logic [CNT_W-1:0]  req_count_i,
    output logic [CNT_W-1:0]  remaining_o,
    output logic              sclk_run_o,
    input  logic              bit_strobe_i,
    input  logic              bit_i,
    input  logic              word_ready_i,
    output logic              word_valid_o,
    output logic [WORD_W-1:0] word_data_o,
    output logic [NB_W-1:0]   word_nbytes_o,
    output logic              rx_done_o,
    output logic              overflow_o
);
    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
        logic [NB_W-1:0]   nbytes;
        logic              ovf;
    } out_state_t;

    out_state_t o_d, o_q;

    logic              run;
    logic              last_byte;
    logic              take;
    logic              byte_end;
    logic              word_end;
    logic [WORD_W-1:0] word;
    logic [NB_W-1:0]   nbytes;

    assign take = bit_strobe_i && run && !req_we_i;

    rxo_req_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (req_we_i),
        .load_val_i  (req_count_i),
        .byte_end_i  (byte_end),
        .remaining_o (remaining_o),
        .run_o       (run),
        .last_byte_o (last_byte),
        .done_o      (rx_done_o)
    );

    rxo_assembler #(.WORD_BYTES(WORD_BYTES), .BYTE_W(BYTE_W)) asm_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clear_i     (req_we_i),
        .take_i      (take),
        .bit_i       (bit_i),
        .last_byte_i (last_byte),
        .byte_end_o  (byte_end),
        .word_end_o  (word_end),
        .word_o      (word),
        .nbytes_o    (nbytes)
    );

    always_comb begin
        o_d       = o_q;
        o_d.valid = 1'b0;
        if (req_we_i) begin
            o_d.ovf = 1'b0;
        end else if (word_end) begin
            if (word_ready_i) begin
                o_d.valid  = 1'b1;
                o_d.data   = word;
                o_d.nbytes = nbytes;
            end else begin
                o_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign sclk_run_o    = run;
    assign word_valid_o  = o_q.valid;
    assign word_data_o   = o_q.data;
    assign word_nbytes_o = o_q.nbytes;
    assign overflow_o    = o_q.ovf;
endmodule

// File: rtl/rxo_spi_rx_packer_chk.sv
module rxo_spi_rx_packer_chk #(
    parameter int unsigned CNT_W      = rxo_pkg::RXO_CNT_W,
    parameter int unsigned WORD_BYTES = rxo_pkg::RXO_WORD_BYTES,
    parameter int unsigned BYTE_W     = rxo_pkg::RXO_BYTE_W,
    localparam int unsigned WORD_W    = WORD_BYTES * BYTE_W,
    localparam int unsigned NB_W      = rxo_pkg::rxo_field_w(WORD_BYTES)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_we_i,
    input logic [CNT_W-1:0]  remaining_o,
    input logic              sclk_run_o,
    input logic              word_valid_o,
    input logic [WORD_W-1:0] word_data_o,
    input logic [NB_W-1:0]   word_nbytes_o,
    input logic              rx_done_o,
    input logic              overflow_o
);
    assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(req_we_i) && (remaining_o != $past(remaining_o)))
        |-> (remaining_o == $past(remaining_o) - CNT_W'(1)));

    assert_run_stops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_done_o |-> (remaining_o == '0) && !sclk_run_o);

    assert_done_word_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_done_o |-> (word_valid_o || overflow_o));

    assert_nbytes_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_valid_o |-> (word_nbytes_o != '0) && (word_nbytes_o <= NB_W'(WORD_BYTES)));

    assert_partial_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_valid_o && (word_nbytes_o < NB_W'(WORD_BYTES)))
        |-> ((word_data_o >> (BYTE_W * word_nbytes_o)) == '0));

    assert_ovf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(overflow_o) && !$past(req_we_i)) |-> overflow_o);

    assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_done_o |=> !rx_done_o);
endmodule

bind rxo_spi_rx_packer rxo_spi_rx_packer_chk #(
    .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES), .BYTE_W(BYTE_W)
) chk_i (.*);

// File: tb/rxo_spi_rx_packer_tb_top.sv
`timescale 1ns/1ps
module rxo_spi_rx_packer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [15:0] cnt = '0;
    logic        stb = 1'b0;
    logic        bitv = 1'b0;
    logic        rdy = 1'b1;
    logic [15:0] remaining;
    logic        run;
    logic        valid;
    logic [31:0] data;
    logic [2:0]  nbytes;
    logic        done;
    logic        ovf;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    int vcount = 0;
    bit started = 0;

    always #4 clk = ~clk;

    rxo_spi_rx_packer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_we_i(we), .req_count_i(cnt),
        .remaining_o(remaining), .sclk_run_o(run), .bit_strobe_i(stb),
        .bit_i(bitv), .word_ready_i(rdy), .word_valid_o(valid),
        .word_data_o(data), .word_nbytes_o(nbytes), .rx_done_o(done),
        .overflow_o(ovf)
    );

    // Behavioural reference model
    int          m_rem = 0;
    int          m_nbits = 0;
    logic [31:0] m_acc = '0;
    bit          m_valid = 0;
    logic [31:0] m_data = '0;
    int          m_nb = 0;
    bit          m_done = 0;
    bit          m_ovf = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_rem = 0; m_nbits = 0; m_acc = '0;
            m_valid = 0; m_done = 0; m_ovf = 0;
        end else begin
            started = 1;
            m_valid = 0;
            m_done = 0;
            if (we) begin
                m_rem = cnt; m_nbits = 0; m_acc = '0; m_ovf = 0;
            end else if (stb && m_rem > 0) begin
                m_acc = (m_acc << 1) | 32'(bitv);
                m_nbits++;
                if (m_nbits % 8 == 0) begin
                    m_rem--;
                    if (m_nbits == 32 || m_rem == 0) begin
                        if (rdy) begin
                            m_valid = 1; m_data = m_acc; m_nb = m_nbits / 8;
                        end else begin
                            m_ovf = 1;
                        end
                        m_acc = '0;
                        m_nbits = 0;
                        if (m_rem == 0) m_done = 1;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Per-cycle comparison and watchdog
    always @(negedge clk) begin
        cycles++;
        if (valid) vcount++;
        if (started && rst_n) begin
            chk(remaining == 16'(m_rem), "R3 remaining", remaining, m_rem);
            chk(run == (m_rem != 0), "R2 run", run, m_rem != 0);
            chk(valid == m_valid, "R4 valid", valid, m_valid);
            if (m_valid) begin
                chk(data == m_data, "R4 data", data, m_data);
                chk(nbytes == 3'(m_nb), "R5 nbytes", nbytes, m_nb);
            end
            chk(done == m_done, "R6 done", done, m_done);
            chk(ovf == m_ovf, "R7 overflow", ovf, m_ovf);
        end
        if (cycles > 150000) begin
            mismatched++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    task automatic step(input bit s, input bit b, input bit w, input logic [15:0] c);
        @(negedge clk);
        stb = s; bitv = b; we = w; cnt = c;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    task automatic request(input logic [15:0] c);
        step(0, 0, 1, c);
        idle(1);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit gap);
        for (int i = 7; i >= 0; i--) begin
            step(1, b[i], 0, 0);
            if (gap) step(0, 0, 0, 0);
        end
    endtask

    initial begin
        int v0;
        idle(3);
        // R1: reset state
        chk(remaining == 0, "R1 remaining", remaining, 0);
        chk(!run && !valid && !done && !ovf, "R1 flags", {run, valid, done, ovf}, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        // R2/R4: two full words
        request(16'd8);
        chk(remaining == 8 && run, "R2 load", remaining, 8);
        for (int i = 0; i < 8; i++) send_byte(8'hA0 + 8'(i), i[0]);
        idle(3);
        chk(!run, "R6 run low", run, 0);

        // R5: partial words of 1, 2, 3 bytes
        for (int n = 5; n <= 7; n++) begin
            request(16'(n));
            for (int i = 0; i < n; i++) send_byte(8'(8'h31 * (i + n)), 0);
            idle(3);
        end

        // R3: strobes while idle are ignored
        v0 = vcount;
        send_byte(8'hFF, 0);
        idle(2);
        chk(remaining == 0 && vcount == v0, "R3 idle strobes", remaining, 0);

        // R2: zero request keeps clock stopped
        request(16'd0);
        chk(!run, "R2 zero request", run, 0);

        // R7: overflow with ready low, then cleared by a request
        request(16'd4);
        rdy = 1'b0;
        for (int i = 0; i < 4; i++) send_byte(8'h5A, 0);
        idle(2);
        rdy = 1'b1;
        chk(ovf, "R7 set", ovf, 1);
        request(16'd2);
        chk(!ovf, "R7 clear", ovf, 0);
        send_byte(8'h12, 0); send_byte(8'h34, 0);
        idle(3);

        // R8: replace mid-byte, then write coinciding with a strobe
        request(16'd10);
        send_byte(8'hC3, 0);
        for (int i = 0; i < 4; i++) step(1, 1, 0, 0);
        request(16'd3);
        chk(remaining == 3, "R8 replace", remaining, 3);
        step(1, 1, 1, 16'd2);
        idle(1);
        chk(remaining == 2, "R8 write wins", remaining, 2);
        send_byte(8'h81, 1); send_byte(8'h7E, 0);
        idle(3);

        // Longer request with mixed ready
        request(16'd13);
        for (int i = 0; i < 13; i++) begin
            rdy = (i != 7);
            send_byte(8'(i * 37 + 5), i % 3 == 0);
        end
        rdy = 1'b1;
        idle(4);
        summary();
    end
endmodule